// File: doc/BRIEF.md
# I2C Controller Interrupt and Soft-Reset Register Bank

This block sits beside an I2C controller and turns its eight single-cycle event strobes into sticky status bits that software can read and clear through a plain 32-bit register port. Each status bit has an enable bit. A single global enable bit gates the combined result. The block drives one level-sensitive interrupt line. The line is high whenever the global enable is set and at least one status bit is both set and enabled.

A separate key register gives software a way to reset the controller. Writing the exact key value 0xA to it produces a one-cycle reset pulse toward the controller. The same write clears the status, enable and global enable registers. Any other value written there is ignored.

The access port takes one request per cycle: valid, write, byte offset and write data. A read returns its data on `rd_data` one clock after the request edge, and the value stays there until the next read.

Top module: `i2c_irq_regbank`

## Requirements
- R1: After the reset input is released, all of the following are zero: the status register, the enable register, the global enable bit, `irq_o`, `ctl_rst_o` and `rd_data`.
- R2: A high pulse on `evt_i[i]` sets status bit i, and the bit stays set until it is cleared. The status register is at offset 0x20 and holds these events in bits [7:0]:
  - bit 0: arbitration lost
  - bit 1: transmit error or transfer done
  - bit 2: transmit queue empty
  - bit 3: receive level reached
  - bit 4: bus idle
  - bit 5: addressed as target
  - bit 6: no longer addressed
  - bit 7: transmit queue half empty
- R3: A write to offset 0x20 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R4: If an event arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R5: The enable register at offset 0x28 stores write-data bits [7:0]. Its upper bits always read as zero.
- R6: The global enable register at offset 0x1C stores only write-data bit 31. All its other bits read as zero.
- R7: `irq_o` is high exactly when the global enable is 1 and the AND of status and enable is nonzero. It follows any register change in the cycle right after the changing edge.
- R8: Writing exactly 0x0000000A to offset 0x40 does two things. `ctl_rst_o` is high for the single cycle after that write. Status, enable and global enable are all zero from that edge on, and an event arriving in the key-write cycle is dropped.
- R9: Writing any other value to offset 0x40 leaves `ctl_rst_o` low and every register unchanged. Reads of 0x40 return zero.
- R10: A read at any other offset returns zero, and a write there changes nothing. `rd_data` changes only on a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid from the cycle after a read request |
| evt_i | input | 8 | Single-cycle event strobes from the controller |
| irq_o | output | 1 | Level interrupt request |
| ctl_rst_o | output | 1 | One-cycle soft reset pulse toward the controller |

## Verification
The main path is tried with a single pair of events, with all eight events at once, and with an event that collides with a clear of the same bit. These patterns separate a correct per-bit latch from a whole-register overwrite, and show whether an event or a clear wins a collision. The interrupt line is observed in four states: gated off by the global bit, enabled, masked after a clear, and enabled again. Each state shows which of the three terms drives it. The key register is tried first with a wrong value and then with the right one. The wrong value shows that only the exact key acts; the right value shows that all three registers clear at once.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  // One-hot select of the register addressed by an access.
  typedef struct packed {
    logic gie;
    logic sts;
    logic ena;
    logic rst;
  } irqb_sel_t;

  localparam int unsigned IRQB_DATA_W = 32;
  localparam int unsigned IRQB_ADDR_W = 8;

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFF_GIE = 'h1C,
  parameter int unsigned OFF_STS = 'h20,
  parameter int unsigned OFF_ENA = 'h28,
  parameter int unsigned OFF_RST = 'h40
) (
  input  logic [ADDR_W-1:0]   addr,
  output irqb_pkg::irqb_sel_t sel
);

  always_comb begin
    sel     = '0;
    sel.gie = (addr == ADDR_W'(OFF_GIE));
    sel.sts = (addr == ADDR_W'(OFF_STS));
    sel.ena = (addr == ADDR_W'(OFF_ENA));
    sel.rst = (addr == ADDR_W'(OFF_RST));
  end

endmodule

// File: rtl/irqb_status.sv
module irqb_status #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_we,
  input  logic [NUM_EVT-1:0] clr_mask,
  input  logic               flush,
  output logic [NUM_EVT-1:0] st_o
);

  logic [NUM_EVT-1:0] st_q;
  logic [NUM_EVT-1:0] st_d;
  logic [NUM_EVT-1:0] st_ce;

  // One sticky cell per event; a new event outranks a clear, a flush outranks both.
  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_cell
    always_comb begin
      st_ce[gi] = flush | evt_i[gi] | (clr_we & clr_mask[gi]);
      if (flush) begin
        st_d[gi] = 1'b0;
      end else if (evt_i[gi]) begin
        st_d[gi] = 1'b1;
      end else begin
        st_d[gi] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[gi] <= 1'b0;
      end else if (st_ce[gi]) begin
        st_q[gi] <= st_d[gi];
      end
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/irqb_mask.sv
module irqb_mask #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GIE_BIT = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_we,
  input  logic               gie_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               flush,
  input  logic [NUM_EVT-1:0] st_i,
  output logic [NUM_EVT-1:0] en_o,
  output logic               gie_o,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] en_q, en_d;
  logic               gie_q, gie_d;
  logic               en_ce, gie_ce;
  logic [NUM_EVT-1:0] pend;

  always_comb begin
    en_ce  = flush | en_we;
    gie_ce = flush | gie_we;
    en_d   = flush ? '0   : wdata[NUM_EVT-1:0];
    gie_d  = flush ? 1'b0 : wdata[GIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_ce) begin
      gie_q <= gie_d;
    end
  end

  assign pend  = st_i & en_q;
  assign irq_o = gie_q & (|pend);
  assign en_o  = en_q;
  assign gie_o = gie_q;

endmodule

// File: rtl/irqb_rstkey.sv
module irqb_rstkey #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY    = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit_o,
  output logic              pulse_o
);

  logic pulse_q;

  assign hit_o = we & (wdata == DATA_W'(KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit_o;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/i2c_irq_regbank.sv
module i2c_irq_regbank #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned DATA_W  = irqb_pkg::IRQB_DATA_W,
  parameter int unsigned ADDR_W  = irqb_pkg::IRQB_ADDR_W,
  parameter int unsigned OFF_GIE = 'h1C,
  parameter int unsigned OFF_STS = 'h20,
  parameter int unsigned OFF_ENA = 'h28,
  parameter int unsigned OFF_RST = 'h40,
  parameter int unsigned KEY     = 'hA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o,
  output logic               ctl_rst_o
);

  localparam int unsigned GIE_BIT = DATA_W - 1;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  irqb_pkg::irqb_sel_t sel;
  logic                wr, rd;
  logic                key_hit;
  logic [NUM_EVT-1:0]  st_q;
  logic [NUM_EVT-1:0] en_q;
  logic                gie_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rd_q;

  assign wr = req_valid &  req_write;
  assign rd = req_valid & ~req_write;

  irqb_decode #(
    .ADDR_W (ADDR_W),
    .OFF_GIE(OFF_GIE),
    .OFF_STS(OFF_STS),
    .OFF_ENA(OFF_ENA),
    .OFF_RST(OFF_RST)
  ) u_decode (
    .addr(req_addr),
    .sel (sel)
  );

  irqb_rstkey #(
    .DATA_W(DATA_W),
    .KEY   (KEY)
  ) u_rstkey (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (wr & sel.rst),
    .wdata  (req_wdata),
    .hit_o  (key_hit),
    .pulse_o(ctl_rst_o)
  );

  irqb_status #(
    .NUM_EVT(NUM_EVT)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt_i   (evt_i),
    .clr_we  (wr & sel.sts),
    .clr_mask(req_wdata[NUM_EVT-1:0]),
    .flush   (key_hit),
    .st_o    (st_q)
  );

  irqb_mask #(
    .NUM_EVT(NUM_EVT),
    .DATA_W (DATA_W),
    .GIE_BIT(GIE_BIT)
  ) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_we (wr & sel.ena),
    .gie_we(wr & sel.gie),
    .wdata (req_wdata),
    .flush (key_hit),
    .st_i  (st_q),
    .en_o  (en_q),
    .gie_o (gie_q),
    .irq_o (irq_o)
  );

  // Read path: select, then register on the request edge.
  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.sts: rd_mux = DATA_W'(st_q);
      sel.ena: rd_mux = DATA_W'(en_q);
      sel.gie: rd_mux[GIE_BIT] = gie_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (rd) begin
      rd_q <= rd_mux;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/i2c_irq_regbank_chk.sv
module i2c_irq_regbank_chk #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFF_RST = 'h40,
  parameter int unsigned KEY     = 'hA
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [DATA_W-1:0]  req_wdata,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [NUM_EVT-1:0] st_q,
  input logic [NUM_EVT-1:0] en_q,
  input logic               gie_q,
  input logic               key_hit,
  input logic               irq_o,
  input logic               ctl_rst_o
);

  logic key_wr, bad_key_wr;
  assign key_wr     = req_valid && req_write && (req_addr == ADDR_W'(OFF_RST))
                      && (req_wdata == DATA_W'(KEY));
  assign bad_key_wr = req_valid && req_write && (req_addr == ADDR_W'(OFF_RST))
                      && (req_wdata != DATA_W'(KEY));

  // R2: without any write, no status bit is lost.
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R4: an event is latched unless the key flush happens in its cycle.
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i != '0) && !key_hit) |=> ((st_q & $past(evt_i)) == $past(evt_i)));

  // R5: enables and global enable hold when no write happens.
  a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ($stable(en_q) && $stable(gie_q)));

  // R7: no interrupt without global enable, status and enable all present.
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q || (st_q == '0) || (en_q == '0)) |-> !irq_o);

  // R8: the key write clears everything and raises the pulse.
  a_r8_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (ctl_rst_o && (st_q == '0) && (en_q == '0) && !gie_q));

  // R8: the pulse only follows a key write.
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst_o |-> $past(key_hit));

  // R9: any other value at the key offset raises no pulse.
  a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key_wr |=> !ctl_rst_o);

endmodule

bind i2c_irq_regbank i2c_irq_regbank_chk #(
  .NUM_EVT(NUM_EVT),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .OFF_RST(OFF_RST),
  .KEY    (KEY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .evt_i    (evt_i),
  .st_q     (st_q),
  .en_q     (en_q),
  .gie_q    (gie_q),
  .key_hit  (key_hit),
  .irq_o    (irq_o),
  .ctl_rst_o(ctl_rst_o)
);

// File: tb/i2c_irq_regbank_bench.sv
module i2c_irq_regbank_bench;

  localparam time HALF = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic [7:0]  evt_i;
  logic        irq_o;
  logic        ctl_rst_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_pending = 1'b0;

  always #HALF clk = ~clk;

  i2c_irq_regbank u_i2c_irq_regbank (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .evt_i    (evt_i),
    .irq_o    (irq_o),
    .ctl_rst_o(ctl_rst_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data one clock after each read request.
  always @(posedge clk) mon_pending <= req_valid & ~req_write;

  always @(negedge clk) begin
    if (mon_pending) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard actual=%08h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; evt_i = ev;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; evt_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    evt_i = ev;
    @(posedge clk); @(negedge clk);
    evt_i = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    chk("R1 ctl_rst_o", {31'b0, ctl_rst_o}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    rd(8'h20, 32'h0, "R1 status");
    rd(8'h28, 32'h0, "R1 enable");
    rd(8'h1C, 32'h0, "R1 global");

    // R2: two events latch
    pulse(8'h05);
    idle();
    rd(8'h20, 32'h05, "R2 status after events 0,2");
    chk("R7 irq off without global", {31'b0, irq_o}, 32'h0);

    // R5 / R6 / R7
    wr(8'h28, 32'hFFFF_FF04, 8'h00);
    rd(8'h28, 32'h04, "R5 enable upper bits zero");
    chk("R7 irq off, global clear", {31'b0, irq_o}, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF, 8'h00);
    chk("R7 irq on", {31'b0, irq_o}, 32'h1);
    rd(8'h1C, 32'h8000_0000, "R6 global bit only");

    // R3: clear bit 2 only
    wr(8'h20, 32'h0000_0004, 8'h00);
    chk("R7 irq off after clear", {31'b0, irq_o}, 32'h0);
    rd(8'h20, 32'h01, "R3 partial clear");

    // R4: event collides with clear of bits 0 and 1
    wr(8'h20, 32'h0000_0003, 8'h02);
    rd(8'h20, 32'h02, "R4 event beats clear");

    // R9: wrong key
    wr(8'h40, 32'h0000_0005, 8'h00);
    chk("R9 no pulse", {31'b0, ctl_rst_o}, 32'h0);
    rd(8'h20, 32'h02, "R9 status kept");
    rd(8'h28, 32'h04, "R9 enable kept");
    rd(8'h1C, 32'h8000_0000, "R9 global kept");
    rd(8'h40, 32'h0, "R9 key reads zero");

    // R7: enable bit 1 raises irq
    wr(8'h28, 32'h0000_0006, 8'h00);
    chk("R7 irq on via bit 1", {31'b0, irq_o}, 32'h1);

    // R8: correct key, event in same cycle dropped
    wr(8'h40, 32'h0000_000A, 8'h80);
    chk("R8 pulse high", {31'b0, ctl_rst_o}, 32'h1);
    chk("R8 irq cleared", {31'b0, irq_o}, 32'h0);
    idle();
    chk("R8 pulse one cycle", {31'b0, ctl_rst_o}, 32'h0);
    rd(8'h20, 32'h0, "R8 status cleared");
    rd(8'h28, 32'h0, "R8 enable cleared");
    rd(8'h1C, 32'h0, "R8 global cleared");

    // R10: unmapped offset
    wr(8'h24, 32'hFFFF_FFFF, 8'h00);
    rd(8'h24, 32'h0, "R10 unmapped reads zero");
    rd(8'h28, 32'h0, "R10 unmapped write no effect");
    idle();
    chk("R10 rd_data held", rd_data, 32'h0);

    // R2: all eight events
    pulse(8'hFF);
    rd(8'h20, 32'hFF, "R2 all events");
    idle();
    chk("R10 rd_data held after read", rd_data, 32'hFF);

    idle();
    finish_run();
  end

endmodule